// File: doc/BRIEF.md
# Vector Byte-Length Load/Store Sequencer

This unit moves between 0 and 16 bytes between a 128-bit vector register and a byte-wide memory port, one byte per clock. A request gives the base address, a 64-bit length operand whose top byte holds the byte count, the direction, and three mode bits. The three mode bits are the lane order (big- or little-endian), a left-justified variant, and a 32-bit addressing mode. A load builds a full 128-bit value starting from zero. A store only issues byte writes.

Memory answers a read in the same cycle as the request. The bench models it as combinational. The count is clamped to 16. Lane 0 is the most significant byte of the vector. The lane order follows each byte's position in the transfer: lanes count downward from 15 in little-endian mode for the normal variant, and upward from 0 otherwise. Address translation and faults are handled elsewhere.

Top module: `vls_unit`

## Requirements
- R1: The byte count is bits 63:56 of `len_opnd`, and bits 55:0 have no effect. A count of n gives exactly n byte transfers, at consecutive addresses starting at `base_addr`.
- R2: A count field of 16 or more is treated as 16, so at most 16 bytes move.
- R3: A load clears the result to zero when it is accepted. Lanes that receive no byte read zero, so a load with a count of zero returns all zero.
- R4: A store with a count of zero makes no memory request, and `done` rises in the cycle after acceptance.
- R5: For the normal variant in little-endian mode (`le_mode`=1, `left_just`=0), the k-th transferred byte (k from 0) uses lane 15-k.
- R6: In big-endian mode, or whenever `left_just`=1, the k-th transferred byte uses lane k.
- R7: Lane j occupies bits 127-8j down to 120-8j of the vector, so lane 0 is bits 127:120.
- R8: The address rises by one for each byte. With `addr32`=1, every issued address has bits 63:32 at zero and the low 32 bits wrap from FFFFFFFF to 0. With `addr32`=0, the full 64 bits increment.
- R9: The transfers occupy cycles 1 to n after the accepting edge. `done` is high for exactly one cycle, in cycle n+1.
- R10: `start` is ignored while `busy` is high. A `start` in the `done` cycle is accepted, and that operation's transfers begin in the next cycle.
- R11: A store drives `mem_we` with the byte of `store_vec` in the lane chosen by R5 to R7. A load never drives `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new operation |
| is_store | input | 1 | 1 = store, 0 = load |
| le_mode | input | 1 | Little-endian lane order |
| left_just | input | 1 | Left-justified variant (always ascending lanes) |
| addr32 | input | 1 | 32-bit address wrap mode |
| base_addr | input | 64 | First byte address |
| len_opnd | input | 64 | Length operand; count in bits 63:56 |
| store_vec | input | 128 | Vector to store, sampled at acceptance |
| mem_req | output | 1 | Byte access this cycle |
| mem_we | output | 1 | Byte access is a write |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the request cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| result_vec | output | 128 | Assembled load value |

## Verification
The completion pulse of one operation and the acceptance of the next can land in the same cycle. In that cycle the finished load's value must still be presented, while the new request is captured and the result clears at the same edge. The bench checks the finished result at the `done` cycle and raises the next `start` in that same cycle. The scoreboard then requires the new operation's first byte in the very next cycle, with no idle gap. A second request is also raised in the middle of a transfer. The scoreboard must see no stray byte from it, and `done` must arrive at the original cycle.

// File: rtl/vls_pkg.sv
package vls_pkg;

    localparam int VLS_VEC_BYTES = 16;
    localparam int VLS_BYTE_W    = 8;
    localparam int VLS_ADDR_W    = 64;
    localparam int VLS_LEN_W     = 64;
    localparam int VLS_FIELD_W   = 8;
    localparam int VLS_NARROW_W  = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } vls_state_e;

    typedef struct packed {
        logic store;
        logic reverse;
        logic narrow;
    } vls_mode_t;

    function automatic vls_mode_t vls_make_mode(input logic st, input logic le,
                                                input logic lj, input logic nar);
        vls_mode_t m;
        m.store   = st;
        m.reverse = le & ~lj;
        m.narrow  = nar;
        return m;
    endfunction

endpackage

// File: rtl/vls_ctrl.sv
module vls_ctrl
    import vls_pkg::*;
#(
    parameter int VEC_BYTES = VLS_VEC_BYTES,
    parameter int LEN_W     = VLS_LEN_W,
    parameter int FIELD_W   = VLS_FIELD_W,
    localparam int CNT_W    = $clog2(VEC_BYTES + 1),
    localparam int IDX_W    = $clog2(VEC_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len_opnd,
    output logic             accept,
    output logic             xfer,
    output logic             fin,
    output logic [IDX_W-1:0] idx
);

    vls_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [FIELD_W-1:0] field;
    logic [CNT_W-1:0] clamped;
    logic             last;

    assign field   = len_opnd[LEN_W-1 -: FIELD_W];
    assign clamped = (field >= FIELD_W'(VEC_BYTES)) ? CNT_W'(VEC_BYTES)
                                                    : CNT_W'(field);
    assign accept  = start && (state_q != ST_XFER);
    assign last    = (CNT_W'(idx_q) + CNT_W'(1)) == cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FIN: begin
                if (accept)
                    state_d = (clamped == '0) ? ST_FIN : ST_XFER;
                else
                    state_d = ST_IDLE;
            end
            ST_XFER: begin
                if (last)
                    state_d = ST_FIN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= clamped;
                idx_q <= '0;
            end else if (state_q == ST_XFER && !last) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign xfer = (state_q == ST_XFER);
    assign fin  = (state_q == ST_FIN);
    assign idx  = idx_q;

endmodule

// File: rtl/vls_addr.sv
module vls_addr
    import vls_pkg::*;
#(
    parameter int ADDR_W   = VLS_ADDR_W,
    parameter int NARROW_W = VLS_NARROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              step,
    input  logic              narrow_in,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr
);

    logic              narrow_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] base_fit;
    logic [ADDR_W-1:0] next_addr;

    generate
        if (ADDR_W > NARROW_W) begin : g_wide
            logic [NARROW_W-1:0] low_inc;
            assign low_inc   = addr_q[NARROW_W-1:0] + NARROW_W'(1);
            assign base_fit  = narrow_in ? {{(ADDR_W-NARROW_W){1'b0}}, base[NARROW_W-1:0]}
                                         : base;
            assign next_addr = narrow_q ? {{(ADDR_W-NARROW_W){1'b0}}, low_inc}
                                        : addr_q + ADDR_W'(1);
        end else begin : g_flat
            logic unused_mode;
            assign unused_mode = narrow_in ^ narrow_q;
            assign base_fit    = base;
            assign next_addr   = addr_q + ADDR_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            narrow_q <= 1'b0;
            addr_q   <= '0;
        end else if (accept) begin
            narrow_q <= narrow_in;
            addr_q   <= base_fit;
        end else if (step) begin
            addr_q   <= next_addr;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/vls_lanes.sv
module vls_lanes
    import vls_pkg::*;
#(
    parameter int VEC_BYTES = VLS_VEC_BYTES,
    parameter int BYTE_W    = VLS_BYTE_W,
    localparam int IDX_W    = $clog2(VEC_BYTES),
    localparam int VEC_W    = VEC_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  vls_mode_t         mode_in,
    input  logic [VEC_W-1:0]  store_vec,
    input  logic              xfer,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] rdata,
    output logic              store_mode,
    output logic [BYTE_W-1:0] wdata,
    output logic [VEC_W-1:0]  vec
);

    logic              store_q;
    logic              reverse_q;
    logic [IDX_W-1:0]  lane_sel;
    logic [BYTE_W-1:0] lane_q [VEC_BYTES];

    assign lane_sel = reverse_q ? (IDX_W'(VEC_BYTES - 1) - idx) : idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q   <= 1'b0;
            reverse_q <= 1'b0;
        end else if (accept) begin
            store_q   <= mode_in.store;
            reverse_q <= mode_in.reverse;
        end
    end

    generate
        for (genvar g = 0; g < VEC_BYTES; g++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst)
                    lane_q[g] <= '0;
                else if (accept)
                    lane_q[g] <= mode_in.store ? store_vec[VEC_W-1-g*BYTE_W -: BYTE_W] : '0;
                else if (xfer && !store_q && lane_sel == IDX_W'(g))
                    lane_q[g] <= rdata;
            end
            assign vec[VEC_W-1-g*BYTE_W -: BYTE_W] = lane_q[g];
        end
    endgenerate

    assign wdata      = (xfer && store_q) ? lane_q[lane_sel] : '0;
    assign store_mode = store_q;

endmodule

// File: rtl/vls_unit.sv
module vls_unit
    import vls_pkg::*;
#(
    parameter int ADDR_W    = VLS_ADDR_W,
    parameter int LEN_W     = VLS_LEN_W,
    parameter int FIELD_W   = VLS_FIELD_W,
    parameter int VEC_BYTES = VLS_VEC_BYTES,
    parameter int BYTE_W    = VLS_BYTE_W,
    parameter int NARROW_W  = VLS_NARROW_W,
    localparam int IDX_W    = $clog2(VEC_BYTES),
    localparam int VEC_W    = VEC_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_store,
    input  logic              le_mode,
    input  logic              left_just,
    input  logic              addr32,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  len_opnd,
    input  logic [VEC_W-1:0]  store_vec,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [VEC_W-1:0]  result_vec
);

    vls_mode_t        mode_in;
    logic             accept;
    logic             xfer;
    logic             fin;
    logic             store_mode;
    logic [IDX_W-1:0] idx;

    assign mode_in = vls_make_mode(is_store, le_mode, left_just, addr32);

    vls_ctrl #(
        .VEC_BYTES (VEC_BYTES),
        .LEN_W     (LEN_W),
        .FIELD_W   (FIELD_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .len_opnd (len_opnd),
        .accept   (accept),
        .xfer     (xfer),
        .fin      (fin),
        .idx      (idx)
    );

    vls_addr #(
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .step      (xfer),
        .narrow_in (mode_in.narrow),
        .base      (base_addr),
        .addr      (mem_addr)
    );

    vls_lanes #(
        .VEC_BYTES (VEC_BYTES),
        .BYTE_W    (BYTE_W)
    ) u_lanes (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .mode_in    (mode_in),
        .store_vec  (store_vec),
        .xfer       (xfer),
        .idx        (idx),
        .rdata      (mem_rdata),
        .store_mode (store_mode),
        .wdata      (mem_wdata),
        .vec        (result_vec)
    );

    assign mem_req = xfer;
    assign mem_we  = xfer && store_mode;
    assign busy    = xfer;
    assign done    = fin;

endmodule

// File: rtl/vls_unit_chk.sv
module vls_unit_chk #(
    parameter int ADDR_W    = 64,
    parameter int LEN_W     = 64,
    parameter int VEC_BYTES = 16,
    parameter int BYTE_W    = 8,
    localparam int VEC_W    = VEC_BYTES * BYTE_W,
    localparam int CNT_W    = $clog2(VEC_BYTES + 1) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              is_store,
    input logic [LEN_W-1:0]  len_opnd,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              done,
    input logic [VEC_W-1:0]  result_vec
);

    logic [CNT_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= '0;
        else if (start && !busy)
            seen_q <= '0;
        else if (mem_req && seen_q != '1)
            seen_q <= seen_q + CNT_W'(1);
    end

    AST_COUNT_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        done |-> seen_q <= CNT_W'(VEC_BYTES)); // R2

    AST_LOAD_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !is_store) |=> result_vec == '0); // R3

    AST_EMPTY_STORE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && is_store && len_opnd[LEN_W-1 -: 8] == 8'd0) |=> (!mem_req && done)); // R4

    AST_ADDR_CONSECUTIVE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> mem_addr[31:0] == $past(mem_addr[31:0]) + 32'd1); // R8

    AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_req) |-> done); // R9

    AST_DONE_NO_TRAFFIC: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req); // R9

    AST_FIRST_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(start)); // R10

    AST_WRITE_IS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_req && !done)); // R11

endmodule

bind vls_unit vls_unit_chk #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .VEC_BYTES (VEC_BYTES),
    .BYTE_W    (BYTE_W)
) u_chk (.*);

// File: tb/vls_unit_bench.sv
module vls_unit_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        we;
        logic [63:0] addr;
        logic [7:0]  wdata;
    } item_t;

    logic         clk = 1'b0;
    logic         rst;
    logic         start, is_store, le_mode, left_just, addr32;
    logic [63:0]  base_addr, len_opnd;
    logic [127:0] store_vec;
    logic         mem_req, mem_we, busy, done;
    logic [63:0]  mem_addr;
    logic [7:0]   mem_wdata, mem_rdata;
    logic [127:0] result_vec;

    item_t        exp_q[$];
    logic [127:0] exp_vec;
    int           exp_n;
    int           checks = 0;
    int           fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vls_unit u_vls_unit (
        .clk(clk), .rst(rst), .start(start), .is_store(is_store),
        .le_mode(le_mode), .left_just(left_just), .addr32(addr32),
        .base_addr(base_addr), .len_opnd(len_opnd), .store_vec(store_vec),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .result_vec(result_vec)
    );

    function automatic logic [7:0] pat(input logic [63:0] a);
        return a[7:0] ^ a[39:32] ^ a[63:56] ^ 8'hA5;
    endfunction

    assign mem_rdata = pat(mem_addr);

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: each memory access must match the next scoreboard entry
    always @(negedge clk) begin : mon
        item_t it;
        if (!rst && mem_req) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected byte access", {64'd0, mem_addr}, 128'd0);
            end else begin
                it = exp_q.pop_front();
                chk(mem_we == it.we, "R11 write enable", {127'd0, mem_we}, {127'd0, it.we});
                chk(mem_addr == it.addr, "R8 byte address", {64'd0, mem_addr}, {64'd0, it.addr});
                if (it.we)
                    chk(mem_wdata == it.wdata, "R11 store byte lane",
                        {120'd0, mem_wdata}, {120'd0, it.wdata});
            end
        end
    end

    // Driver: computes expected traffic and load value, then raises start
    task automatic launch(input bit st, input bit le, input bit lj, input bit a32,
                          input logic [63:0] base, input logic [7:0] len8,
                          input logic [55:0] low, input logic [127:0] vec);
        logic [63:0] a;
        int          lane;
        item_t       it;
        exp_n   = (len8 >= 8'd16) ? 16 : int'(len8);
        exp_vec = '0;
        a = a32 ? {32'd0, base[31:0]} : base;
        for (int k = 0; k < exp_n; k++) begin
            lane     = (le && !lj) ? 15 - k : k;
            it.we    = st;
            it.addr  = a;
            it.wdata = st ? vec[127-8*lane -: 8] : 8'd0;
            exp_q.push_back(it);
            exp_vec[127-8*lane -: 8] = pat(a);
            a = a32 ? {32'd0, a[31:0] + 32'd1} : a + 64'd1;
        end
        is_store  = st;
        le_mode   = le;
        left_just = lj;
        addr32    = a32;
        base_addr = base;
        len_opnd  = {len8, low};
        store_vec = vec;
        start     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic wait_done(input int c0, input bit is_load, input bit pulse_chk,
                             input string tag);
        int           c = c0;
        int           n = exp_n;
        logic [127:0] ev = exp_vec;
        while (!done && c < 64) begin
            @(negedge clk);
            c++;
        end
        chk(c == n + 1, {tag, " R9 done cycle"}, 128'(c), 128'(n + 1));
        if (is_load)
            chk(result_vec == ev, {tag, " load value"}, result_vec, ev);
        chk(exp_q.size() == 0, {tag, " R1 transfer count"}, 128'(exp_q.size()), 128'd0);
        if (pulse_chk) begin
            @(negedge clk);
            chk(done == 1'b0, "R9 done one cycle", {127'd0, done}, 128'd0);
        end
    endtask

    task automatic run_op(input bit st, input bit le, input bit lj, input bit a32,
                          input logic [63:0] base, input logic [7:0] len8,
                          input logic [55:0] low, input logic [127:0] vec,
                          input string tag);
        launch(st, le, lj, a32, base, len8, low, vec);
        wait_done(1, !st, 1'b1, tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [127:0] sv = 128'h00112233445566778899AABBCCDDEEFF;
        rst = 1'b1; start = 0; is_store = 0; le_mode = 0; left_just = 0; addr32 = 0;
        base_addr = '0; len_opnd = '0; store_vec = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R9 reset idle", {125'd0, busy, done, mem_req}, 128'd0);
        chk(result_vec == '0, "R3 reset result", result_vec, 128'd0);

        // R7: lane 0 sits in the top byte
        run_op(0, 0, 0, 0, 64'h0000_0001_0000_0020, 8'd1, 56'd0, '0, "R7 lane0");
        chk(result_vec[127:120] == pat(64'h0000_0001_0000_0020) && result_vec[119:0] == '0,
            "R7 top byte", result_vec, {pat(64'h0000_0001_0000_0020), 120'd0});

        // Sweep: all counts, both lane orders, both variants, load and store
        for (int st = 0; st < 2; st++)
            for (int le = 0; le < 2; le++)
                for (int lj = 0; lj < 2; lj++)
                    for (int ln = 0; ln < 19; ln++) begin
                        logic [7:0] l8 = (ln == 18) ? 8'hFF : 8'(ln);
                        run_op(st[0], le[0], lj[0], 1'b0,
                               64'h1000_0000_0000_0040 + 64'(ln * 3), l8,
                               ln[0] ? 56'hFF_FFFF_FFFF_FFFF : 56'd0,
                               sv ^ {16{l8}},
                               (le == 1 && lj == 0) ? "R1 R2 R5 sweep" : "R1 R2 R6 sweep");
                    end

        // R3: zero-count load after a full load returns zero
        run_op(0, 0, 0, 0, 64'h40, 8'd16, 56'd0, '0, "R3 full load");
        run_op(0, 0, 0, 0, 64'h80, 8'd0, 56'h12_3456, '0, "R3 zero load");
        chk(result_vec == '0, "R3 zero count clears", result_vec, 128'd0);

        // R4: zero-count store, done next cycle, scoreboard empty
        run_op(1, 1, 0, 0, 64'h90, 8'd0, 56'hAB, sv, "R4 empty store");

        // R2: count field 0x20 clamps to 16
        run_op(1, 0, 1, 0, 64'h100, 8'h20, 56'd0, sv, "R2 clamp store");

        // R8: 32-bit wrap versus 64-bit carry
        run_op(0, 1, 0, 1, 64'hDEAD_BEEF_FFFF_FFF8, 8'd16, 56'd0, '0, "R8 narrow wrap");
        run_op(0, 1, 0, 0, 64'h0000_0000_FFFF_FFF8, 8'd16, 56'd0, '0, "R8 wide carry");

        // R10: start during a transfer is ignored
        launch(0, 1, 0, 0, 64'h200, 8'd8, 56'd0, '0);
        @(negedge clk);
        is_store = 1'b1; len_opnd = {8'd3, 56'd0}; base_addr = 64'h999; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(3, 1'b1, 1'b1, "R10 ignore busy start");

        // R10: start in the done cycle is accepted without a gap
        launch(0, 0, 0, 0, 64'h300, 8'd4, 56'd0, '0);
        wait_done(1, 1'b1, 1'b0, "R10 first of pair");
        launch(1, 0, 0, 0, 64'h400, 8'd3, 56'd0, sv);
        wait_done(1, 1'b0, 1'b1, "R10 back to back");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule